// File: doc/BRIEF.md
# Descriptor Channel Command Engine

One channel of a crypto co-processor's command front end. Software places a chain of eight-word descriptors in memory, loads the address of the first one into the channel's pointer register and then adds to the channel's semaphore. While the semaphore is nonzero, the engine reads a descriptor word by word over a single-outstanding memory read port. It decodes the two control words and hands the job to an execution unit over a valid/ready handshake. It then waits for the unit's done pulse and writes a status word back into the descriptor. It can also raise a one-cycle completion pulse and decrement the semaphore. Finally it moves the pointer register to the descriptor's link word.

Descriptor words, at word offsets 0 to 7 from the descriptor base: link address, control word A, control word B, source, destination, size, payload pointer, status. A link of zero ends the chain. A descriptor that fails its checks is not dispatched. Its error code is recorded, and the channel stops fetching until software clears that code.

Top module: `chan_cmd_engine`

## Requirements
- R1: After reset the pointer, semaphore and status registers read zero and no memory request, job or completion pulse is active.
- R2: When the semaphore is nonzero, the pointer is nonzero and the status register is zero, the engine reads the eight descriptor words at base+0, base+4, ... base+28 in that order. The read address is held until mem_rd_valid returns the word.
- R3: Register map (byte offsets on reg_addr): 0x00 pointer (read/write), 0x10 semaphore (a write adds reg_wdata to the count; a read returns the count), 0x20 status (read), 0x28 status clear (write). Any other offset reads zero.
- R4: Control word A bits 5, 6, 8, 9, 11, 12 and 13 appear on job_flags bits 0 to 6 in that order (cipher enable, hash enable, encrypt, cipher init, payload is key, hash init, hash end). Control word B bit 4 drives job_cbc (1 = chained mode), bits 19:16 drive job_hash_sel and bits 3:0 drive job_cipher_sel. Source, destination, size and payload words are passed unchanged, and job_valid stays high until job_ready.
- R5: When a job completes, the engine writes the status word to base+28 with the error code in bits 7:0 (zero on success). This write is acknowledged before any completion pulse.
- R6: done_irq pulses for exactly one cycle per finished descriptor, and only when control word A bit 0 is set.
- R7: Control word A bit 1 decrements the semaphore once the descriptor finishes. With the count at zero the engine stops before the next fetch, and it resumes when software adds to the count.
- R8: On finishing a descriptor the pointer register takes the link word. A link of zero leaves the channel idle.
- R9: A descriptor with both cipher and hash enabled is rejected with code 0x01, and one with size zero is rejected with code 0x02; the first check wins. A rejected descriptor is not dispatched. Its code is written back and latched in status bits 7:0, and no fetch starts while the status register is nonzero.
- R10: Writing to the status clear offset clears only the status bits written as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_rd_req | output | 1 | Descriptor read request, held until valid |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_valid | input | 1 | Read data valid, completes the request |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Status write request, held until ack |
| mem_wr_addr | output | 32 | Status word address |
| mem_wr_data | output | 32 | Status word value |
| mem_wr_ack | input | 1 | Status write accepted |
| job_valid | output | 1 | Job presented to the execution unit |
| job_ready | input | 1 | Execution unit accepts the job |
| job_src | output | 32 | Source address |
| job_dst | output | 32 | Destination address |
| job_size | output | 32 | Byte count |
| job_payload | output | 32 | Payload pointer |
| job_flags | output | 7 | Operation flags, see R4 |
| job_cbc | output | 1 | Cipher chaining mode |
| job_hash_sel | output | 4 | Hash algorithm select |
| job_cipher_sel | output | 4 | Cipher select |
| job_done | input | 1 | Execution unit finished the job |
| done_irq | output | 1 | Completion pulse |

## Verification
The assertions assume the memory returns mem_rd_valid only while a read is requested and acks a write only while one is requested. They also assume job_done arrives only after a job was accepted and that software never adds enough to wrap the semaphore. The bench keeps to these assumptions: its memory model answers one request at a time after a fixed latency, its execution stub returns done a few cycles after each accepted job, and the semaphore never holds more than two. Register writes are made only while the channel is idle or blocked, so no write competes with the engine's own update of a register.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;
  localparam int DESC_WORDS = 8;
  localparam int ERR_W      = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_ISSUE, ST_RUN, ST_WBACK, ST_FIN
  } seq_state_e;

  // word slots inside a descriptor
  localparam int W_LINK = 0;
  localparam int W_CA   = 1;
  localparam int W_CB   = 2;
  localparam int W_SRC  = 3;
  localparam int W_DST  = 4;
  localparam int W_SIZE = 5;
  localparam int W_PAY  = 6;
  localparam int W_STAT = 7;

  // control word A bits kept by the sequencer; slot 0 completion pulse,
  // slot 1 semaphore decrement, slots 2..8 the job flags
  localparam int CA_KEEP = 9;
  localparam int CA_POS [CA_KEEP] = '{0, 1, 5, 6, 8, 9, 11, 12, 13};
  localparam int K_IRQ  = 0;
  localparam int K_DEC  = 1;
  localparam int FLAG_W = CA_KEEP - 2;

  // control word B fields: {hash select, chain mode, cipher select}
  localparam int CB_KEEP = 9;

  // register byte offsets
  localparam logic [7:0] OFS_PTR = 8'h00;
  localparam logic [7:0] OFS_SEM = 8'h10;
  localparam logic [7:0] OFS_ST  = 8'h20;
  localparam logic [7:0] OFS_CLR = 8'h28;

  localparam logic [ERR_W-1:0] ERR_NONE  = 8'h00;
  localparam logic [ERR_W-1:0] ERR_COMBO = 8'h01;
  localparam logic [ERR_W-1:0] ERR_EMPTY = 8'h02;
endpackage

// File: rtl/chan_cmd_regs.sv
module chan_cmd_regs
  import chan_cmd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             fin,
  input  logic             fin_dec,
  input  logic [AW-1:0]    fin_link,
  input  logic [ERR_W-1:0] fin_err,
  output logic [AW-1:0]    cmd_ptr,
  output logic [SEM_W-1:0] sem_count,
  output logic [ERR_W-1:0] err_stat
);
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [SEM_W-1:0] sem_q, sem_d, sem_add, sem_sub;
  logic [ERR_W-1:0] st_q, st_d;
  logic             wr_ptr, wr_sem, wr_clr;

  assign wr_ptr = reg_we && (reg_addr == OFS_PTR);
  assign wr_sem = reg_we && (reg_addr == OFS_SEM);
  assign wr_clr = reg_we && (reg_addr == OFS_CLR);

  always_comb begin
    ptr_d = ptr_q;
    if (fin)         ptr_d = fin_link;
    else if (wr_ptr) ptr_d = reg_wdata[AW-1:0];
  end

  always_comb begin
    sem_add = wr_sem ? reg_wdata[SEM_W-1:0] : '0;
    sem_sub = (fin && fin_dec) ? SEM_W'(1) : '0;
    sem_d   = sem_q + sem_add - sem_sub;
  end

  always_comb begin
    st_d = st_q;
    if (wr_clr) st_d = st_q & ~reg_wdata[ERR_W-1:0];
    if (fin && (fin_err != ERR_NONE)) st_d = fin_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      sem_q <= '0;
      st_q  <= '0;
    end else begin
      ptr_q <= ptr_d;
      sem_q <= sem_d;
      st_q  <= st_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_PTR: reg_rdata = 32'(ptr_q);
      OFS_SEM: reg_rdata = 32'(sem_q);
      OFS_ST:  reg_rdata = 32'(st_q);
      default: reg_rdata = '0;
    endcase
  end

  assign cmd_ptr   = ptr_q;
  assign sem_count = sem_q;
  assign err_stat  = st_q;
endmodule

// File: rtl/chan_desc_decode.sv
module chan_desc_decode
  import chan_cmd_pkg::*;
#(
  parameter bit ALLOW_BOTH = 1'b0
) (
  input  logic [FLAG_W-1:0]  op_bits,
  input  logic [CB_KEEP-1:0] fmt_bits,
  input  logic [31:0]        size,
  output logic [FLAG_W-1:0]  flags,
  output logic               cbc,
  output logic [3:0]         hash_sel,
  output logic [3:0]         cipher_sel,
  output logic [ERR_W-1:0]   err_code
);
  logic combo_bad;

  assign flags      = op_bits;
  assign cipher_sel = fmt_bits[3:0];
  assign cbc        = fmt_bits[4];
  assign hash_sel   = fmt_bits[8:5];

  generate
    if (ALLOW_BOTH) begin : g_both_ok
      assign combo_bad = 1'b0;
    end else begin : g_both_bad
      assign combo_bad = op_bits[0] & op_bits[1];
    end
  endgenerate

  always_comb begin
    if (combo_bad)          err_code = ERR_COMBO;
    else if (size == 32'd0) err_code = ERR_EMPTY;
    else                    err_code = ERR_NONE;
  end
endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import chan_cmd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEM_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      cmd_ptr,
  input  logic [SEM_W-1:0]   sem_count,
  input  logic [ERR_W-1:0]   err_stat,
  input  logic [ERR_W-1:0]   err_code,
  output logic               mem_rd_req,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [31:0]        mem_rd_data,
  output logic               mem_wr_req,
  output logic [AW-1:0]      mem_wr_addr,
  output logic [31:0]        mem_wr_data,
  input  logic               mem_wr_ack,
  output logic               job_valid,
  input  logic               job_ready,
  input  logic               job_done,
  output logic               fin,
  output logic [CA_KEEP-1:0] ctl_q,
  output logic [CB_KEEP-1:0] fmt_q,
  output logic [AW-1:0]      link_q,
  output logic [AW-1:0]      src_q,
  output logic [AW-1:0]      dst_q,
  output logic [31:0]        size_q,
  output logic [AW-1:0]      pay_q
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);
  localparam logic [AW-1:0] STAT_OFS = AW'(4 * W_STAT);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [AW-1:0]    base_q, base_d;
  logic             start_ok, cap_en;
  logic [CA_KEEP-1:0] ctl_pick;
  logic [CB_KEEP-1:0] fmt_pick;

  genvar g;
  generate
    for (g = 0; g < CA_KEEP; g++) begin : g_pick
      assign ctl_pick[g] = mem_rd_data[CA_POS[g]];
    end
  endgenerate
  assign fmt_pick = {mem_rd_data[19:16], mem_rd_data[4], mem_rd_data[3:0]};

  assign start_ok = (sem_count != '0) && (cmd_ptr != '0) && (err_stat == ERR_NONE);
  assign cap_en   = (state_q == ST_FETCH) && mem_rd_valid;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    base_d  = base_q;
    case (state_q)
      ST_IDLE: if (start_ok) begin
        state_d = ST_FETCH;
        idx_d   = '0;
        base_d  = cmd_ptr;
      end
      ST_FETCH: if (mem_rd_valid) begin
        if (idx_q == IDX_LAST) state_d = ST_CHECK;
        else                   idx_d   = idx_q + 1'b1;
      end
      ST_CHECK: state_d = (err_code != ERR_NONE) ? ST_WBACK : ST_ISSUE;
      ST_ISSUE: if (job_ready)  state_d = ST_RUN;
      ST_RUN:   if (job_done)   state_d = ST_WBACK;
      ST_WBACK: if (mem_wr_ack) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      ctl_q  <= '0;
      fmt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      size_q <= '0;
      pay_q  <= '0;
    end else if (cap_en) begin
      case (int'(idx_q))
        W_LINK: link_q <= AW'(mem_rd_data);
        W_CA:   ctl_q  <= ctl_pick;
        W_CB:   fmt_q  <= fmt_pick;
        W_SRC:  src_q  <= AW'(mem_rd_data);
        W_DST:  dst_q  <= AW'(mem_rd_data);
        W_SIZE: size_q <= mem_rd_data;
        W_PAY:  pay_q  <= AW'(mem_rd_data);
        default: ;
      endcase
    end
  end

  assign mem_rd_req  = (state_q == ST_FETCH);
  assign mem_rd_addr = base_q + AW'({idx_q, 2'b00});
  assign mem_wr_req  = (state_q == ST_WBACK);
  assign mem_wr_addr = base_q + STAT_OFS;
  assign mem_wr_data = 32'(err_code);
  assign job_valid   = (state_q == ST_ISSUE);
  assign fin         = (state_q == ST_FIN);
endmodule

// File: rtl/chan_cmd_engine.sv
module chan_cmd_engine
  import chan_cmd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SEM_W      = 8,
  parameter bit ALLOW_BOTH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd_req,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_req,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              job_valid,
  input  logic              job_ready,
  output logic [AW-1:0]     job_src,
  output logic [AW-1:0]     job_dst,
  output logic [31:0]       job_size,
  output logic [AW-1:0]     job_payload,
  output logic [FLAG_W-1:0] job_flags,
  output logic              job_cbc,
  output logic [3:0]        job_hash_sel,
  output logic [3:0]        job_cipher_sel,
  input  logic              job_done,
  output logic              done_irq
);
  logic [AW-1:0]      cmd_ptr, link_q;
  logic [SEM_W-1:0]   sem_count;
  logic [ERR_W-1:0]   err_stat, err_code;
  logic               fin;
  logic [CA_KEEP-1:0] ctl_q;
  logic [CB_KEEP-1:0] fmt_q;

  chan_cmd_regs #(.AW(AW), .SEM_W(SEM_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .fin       (fin),
    .fin_dec   (ctl_q[K_DEC]),
    .fin_link  (link_q),
    .fin_err   (err_code),
    .cmd_ptr   (cmd_ptr),
    .sem_count (sem_count),
    .err_stat  (err_stat)
  );

  chan_seq #(.AW(AW), .SEM_W(SEM_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_ptr      (cmd_ptr),
    .sem_count    (sem_count),
    .err_stat     (err_stat),
    .err_code     (err_code),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ack   (mem_wr_ack),
    .job_valid    (job_valid),
    .job_ready    (job_ready),
    .job_done     (job_done),
    .fin          (fin),
    .ctl_q        (ctl_q),
    .fmt_q        (fmt_q),
    .link_q       (link_q),
    .src_q        (job_src),
    .dst_q        (job_dst),
    .size_q       (job_size),
    .pay_q        (job_payload)
  );

  chan_desc_decode #(.ALLOW_BOTH(ALLOW_BOTH)) dec_i (
    .op_bits    (ctl_q[CA_KEEP-1:2]),
    .fmt_bits   (fmt_q),
    .size       (job_size),
    .flags      (job_flags),
    .cbc        (job_cbc),
    .hash_sel   (job_hash_sel),
    .cipher_sel (job_cipher_sel),
    .err_code   (err_code)
  );

  assign done_irq = fin & ctl_q[K_IRQ];
endmodule

// File: rtl/chan_cmd_engine_chk.sv
module chan_cmd_engine_chk #(
  parameter int AW    = 32,
  parameter int SEM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_rd_req,
  input logic [AW-1:0]    mem_rd_addr,
  input logic             mem_rd_valid,
  input logic             mem_wr_req,
  input logic             mem_wr_ack,
  input logic             job_valid,
  input logic             job_ready,
  input logic [31:0]      job_size,
  input logic             done_irq,
  input logic [SEM_W-1:0] sem_count
);
  assert_rd_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> $stable(mem_rd_addr));

  assert_job_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && !job_ready |=> job_valid);

  assert_no_rd_wr_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  assert_irq_after_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(mem_wr_req && mem_wr_ack));

  assert_fetch_needs_sem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_req) |-> sem_count != '0);

  assert_stop_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sem_count == '0 |=> !$rose(mem_rd_req));

  assert_no_empty_job_R9: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> job_size != 32'd0);
endmodule

bind chan_cmd_engine chan_cmd_engine_chk #(.AW(AW), .SEM_W(SEM_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_valid (mem_rd_valid),
  .mem_wr_req   (mem_wr_req),
  .mem_wr_ack   (mem_wr_ack),
  .job_valid    (job_valid),
  .job_ready    (job_ready),
  .job_size     (job_size),
  .done_irq     (done_irq),
  .sem_count    (sem_count)
);

// File: tb/chan_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module chan_cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_rd_req, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        mem_wr_req, mem_wr_ack;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        job_valid, job_ready, job_done, done_irq;
  logic [31:0] job_src, job_dst, job_size, job_payload;
  logic [6:0]  job_flags;
  logic        job_cbc;
  logic [3:0]  job_hash_sel, job_cipher_sel;

  always #2.5 clk = ~clk;

  chan_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .job_valid(job_valid), .job_ready(job_ready), .job_src(job_src),
    .job_dst(job_dst), .job_size(job_size), .job_payload(job_payload),
    .job_flags(job_flags), .job_cbc(job_cbc), .job_hash_sel(job_hash_sel),
    .job_cipher_sel(job_cipher_sel), .job_done(job_done), .done_irq(done_irq)
  );

  typedef struct {
    logic [31:0] src, dst, size, pay;
    logic [6:0]  flags;
    logic        cbc;
    logic [3:0]  hs, cs;
  } job_t;

  int n_checks = 0;
  int n_fail   = 0;
  int irq_cnt  = 0;
  bit finished = 1'b0;
  logic [31:0] mem [int];
  logic [31:0] exp_rd [$];
  logic [31:0] exp_wb_addr [$];
  logic [31:0] exp_wb_data [$];
  job_t        exp_job [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // memory read model: one request at a time, two-cycle latency
  int  rd_lat = 0;
  bit  rd_pend = 1'b0;
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (rst_n && mem_rd_req && !rd_pend) begin
      rd_pend = 1'b1;
      rd_lat  = 2;
      if (exp_rd.size() == 0) chk("R2 unexpected fetch", mem_rd_addr, 32'hFFFF_FFFF);
      else chk("R2 fetch address", mem_rd_addr, exp_rd.pop_front());
    end else if (rd_pend) begin
      rd_lat--;
      if (rd_lat == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem.exists(int'(mem_rd_addr)) ? mem[int'(mem_rd_addr)] : 32'd0;
        rd_pend      = 1'b0;
      end
    end
  end

  // memory write model: one-cycle ack, scoreboard compare
  always @(negedge clk) begin
    if (rst_n && mem_wr_req && !mem_wr_ack) begin
      mem_wr_ack = 1'b1;
      if (exp_wb_addr.size() == 0) chk("R5 unexpected write", mem_wr_addr, 32'hFFFF_FFFF);
      else begin
        chk("R5 status address", mem_wr_addr, exp_wb_addr.pop_front());
        chk("R5 status value", mem_wr_data, exp_wb_data.pop_front());
      end
    end else mem_wr_ack = 1'b0;
  end

  // execution stub and job monitor
  int done_cnt = 0;
  always @(negedge clk) begin
    job_done = 1'b0;
    if (done_cnt != 0) begin
      done_cnt--;
      if (done_cnt == 0) job_done = 1'b1;
    end
    if (rst_n && job_valid) begin
      if (exp_job.size() == 0) chk("R9 unexpected job", job_src, 32'hFFFF_FFFF);
      else begin
        job_t e;
        e = exp_job.pop_front();
        chk("R4 source", job_src, e.src);
        chk("R4 destination", job_dst, e.dst);
        chk("R4 size", job_size, e.size);
        chk("R4 payload", job_payload, e.pay);
        chk("R4 flags", 32'(job_flags), 32'(e.flags));
        chk("R4 format", {23'd0, job_cbc, job_hash_sel, job_cipher_sel}, {23'd0, e.cbc, e.hs, e.cs});
      end
      done_cnt = 3;
    end
  end

  always @(negedge clk) if (rst_n && done_irq) irq_cnt++;

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] b, lnk, ca, cb, src, dst, sz, pay);
    mem[int'(b)]      = lnk;
    mem[int'(b + 4)]  = ca;
    mem[int'(b + 8)]  = cb;
    mem[int'(b + 12)] = src;
    mem[int'(b + 16)] = dst;
    mem[int'(b + 20)] = sz;
    mem[int'(b + 24)] = pay;
    mem[int'(b + 28)] = 32'hDEAD_BEEF;
  endtask

  task automatic expect_desc(input logic [31:0] b, input logic [31:0] code);
    for (int k = 0; k < 8; k++) exp_rd.push_back(b + 32'(4 * k));
    exp_wb_addr.push_back(b + 32'd28);
    exp_wb_data.push_back(code);
  endtask

  task automatic expect_job(input logic [31:0] src, dst, sz, pay, input logic [6:0] fl,
                            input logic cbc, input logic [3:0] hs, cs);
    job_t e;
    e.src = src; e.dst = dst; e.size = sz; e.pay = pay;
    e.flags = fl; e.cbc = cbc; e.hs = hs; e.cs = cs;
    exp_job.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
    mem_rd_valid = 1'b0; mem_rd_data = '0; mem_wr_ack = 1'b0;
    job_ready = 1'b1; job_done = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(8'h00, rd); chk("R1 pointer", rd, 0);
    reg_read(8'h10, rd); chk("R1 semaphore", rd, 0);
    reg_read(8'h20, rd); chk("R1 status", rd, 0);
    chk("R1 outputs", {28'd0, mem_rd_req, mem_wr_req, job_valid, done_irq}, 0);
    reg_read(8'h30, rd); chk("R3 unmapped offset", rd, 0);

    // two-descriptor chain, semaphore 2
    put_desc(32'h100, 32'h200, 32'h0B23, 32'h10, 32'h1000, 32'h2000, 64, 32'h3000);
    put_desc(32'h200, 32'h0, 32'h3043, 32'h0002_0000, 32'h4000, 32'h0, 16, 32'h5000);
    expect_desc(32'h100, 0);
    expect_job(32'h1000, 32'h2000, 64, 32'h3000, 7'h1D, 1'b1, 4'd0, 4'd0);
    expect_desc(32'h200, 0);
    expect_job(32'h4000, 32'h0, 16, 32'h5000, 7'h62, 1'b0, 4'd2, 4'd0);
    reg_write(8'h00, 32'h100);
    reg_read(8'h00, rd); chk("R3 pointer write", rd, 32'h100);
    reg_write(8'h10, 32'd2);
    repeat (150) @(negedge clk);
    reg_read(8'h10, rd); chk("R7 semaphore after chain", rd, 0);
    reg_read(8'h00, rd); chk("R8 pointer after chain end", rd, 0);
    chk("R6 pulses after chain", irq_cnt, 2);

    // semaphore stop and resume
    put_desc(32'h300, 32'h400, 32'h0023, 32'h0, 32'h10, 32'h20, 32, 32'h30);
    put_desc(32'h400, 32'h0, 32'h0022, 32'h1, 32'h40, 32'h50, 48, 32'h60);
    expect_desc(32'h300, 0);
    expect_job(32'h10, 32'h20, 32, 32'h30, 7'h01, 1'b0, 4'd0, 4'd0);
    reg_write(8'h00, 32'h300);
    reg_write(8'h10, 32'd1);
    repeat (100) @(negedge clk);
    reg_read(8'h00, rd); chk("R7 stopped at link", rd, 32'h400);
    reg_read(8'h10, rd); chk("R7 semaphore zero", rd, 0);
    chk("R6 pulse count", irq_cnt, 3);
    expect_desc(32'h400, 0);
    expect_job(32'h40, 32'h50, 48, 32'h60, 7'h01, 1'b0, 4'd0, 4'd1);
    reg_write(8'h10, 32'd1);
    repeat (100) @(negedge clk);
    reg_read(8'h00, rd); chk("R8 pointer zero after resume", rd, 0);
    chk("R6 no pulse without request bit", irq_cnt, 3);

    // no decrement requested
    put_desc(32'h500, 32'h0, 32'h0040, 32'h0002_0000, 32'h70, 32'h0, 8, 32'h0);
    expect_desc(32'h500, 0);
    expect_job(32'h70, 32'h0, 8, 32'h0, 7'h02, 1'b0, 4'd2, 4'd0);
    reg_write(8'h00, 32'h500);
    reg_write(8'h10, 32'd1);
    repeat (100) @(negedge clk);
    reg_read(8'h10, rd); chk("R7 no decrement", rd, 1);
    reg_read(8'h00, rd); chk("R8 pointer zero", rd, 0);

    // both engines requested: rejected, channel blocked
    put_desc(32'h600, 32'h0, 32'h0063, 32'h0, 32'h80, 32'h90, 16, 32'hA0);
    expect_desc(32'h600, 32'h01);
    reg_write(8'h00, 32'h600);
    repeat (100) @(negedge clk);
    reg_read(8'h20, rd); chk("R9 combo status", rd, 32'h01);
    reg_read(8'h10, rd); chk("R9 semaphore after reject", rd, 0);
    chk("R6 pulse on reject", irq_cnt, 4);
    put_desc(32'h700, 32'h0, 32'h0023, 32'h0, 32'hB0, 32'hC0, 48, 32'hD0);
    reg_write(8'h00, 32'h700);
    reg_write(8'h10, 32'd1);
    repeat (80) @(negedge clk);
    reg_read(8'h00, rd); chk("R9 blocked while status set", rd, 32'h700);
    expect_desc(32'h700, 0);
    expect_job(32'hB0, 32'hC0, 48, 32'hD0, 7'h01, 1'b0, 4'd0, 4'd0);
    reg_write(8'h28, 32'h01);
    reg_read(8'h20, rd); chk("R10 status cleared", rd, 0);
    repeat (100) @(negedge clk);
    reg_read(8'h00, rd); chk("R8 pointer after unblocked run", rd, 0);
    chk("R6 pulse count after unblock", irq_cnt, 5);

    // zero size rejected; partial clear
    put_desc(32'h800, 32'h0, 32'h0023, 32'h0, 32'hE0, 32'hF0, 0, 32'h0);
    expect_desc(32'h800, 32'h02);
    reg_write(8'h00, 32'h800);
    reg_write(8'h10, 32'd1);
    repeat (100) @(negedge clk);
    reg_read(8'h20, rd); chk("R9 empty status", rd, 32'h02);
    reg_write(8'h28, 32'h01);
    reg_read(8'h20, rd); chk("R10 unmatched bit kept", rd, 32'h02);
    reg_write(8'h28, 32'h02);
    reg_read(8'h20, rd); chk("R10 matched bit cleared", rd, 0);

    chk("R2 all fetches seen", exp_rd.size(), 0);
    chk("R5 all status writes seen", exp_wb_addr.size(), 0);
    chk("R4 all jobs seen", exp_job.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule